// File: doc/BRIEF.md
# Load/Store Access Sequencer

This block carries out the memory-class instructions of a small 24-bit core. It takes an instruction word on an issue strobe and decodes it. It forms an effective address from register operands and a sign-extended immediate. It then drives a synchronous, word-wide memory port. Single-word accesses take one memory cycle. Doubleword accesses take two back-to-back memory cycles and move an even/odd register pair.

The register file sits outside the block. The unit publishes three register selects and reads back the base, the index and a store-data pair; the pair is the register named by the select and its odd neighbour. Load results leave through a pair-wide write-back port, with a two-bit write mask, in the cycle after the last memory request. Memory is word-addressed, and a read request returns its data on the following cycle.

Top module: `lsu_top`

## Requirements
- R1: An instruction is a memory operation only when its bits [23:21] are 100; any other value on issue causes no memory request, no done pulse and no write-back.
- R2: With opcode bit 18 clear (base mode) the address is register A (bits [17:14]) plus the sign-extended 10-bit immediate in bits [9:0], modulo 2^24.
- R3: With opcode bit 18 set (indexed mode) the address is register A plus register B (bits [13:10] hold D, bits [9:6] hold B) plus the sign-extended 6-bit immediate in bits [5:0], modulo 2^24.
- R4: A word store (bit 19 set, bit 20 clear) raises the memory request with write enable in the issue cycle, writing register D; done pulses in the next cycle with no write-back.
- R5: A word load (bits 19 and 20 clear) requests a read in the issue cycle; in the next cycle done pulses and write-back presents the read data on the low lane, index D, mask 01.
- R6: A doubleword access (bit 20 set) issues requests to the address and then the address plus one on consecutive cycles, low word first; busy is high only during the second request, and done pulses in the cycle after it.
- R7: A doubleword store writes the even register of the pair selected by D to the lower address and the odd register to the upper address.
- R8: A doubleword load writes back both words in one cycle: index D with bit 0 cleared, low lane from the lower address, high lane from the upper address, mask 11.
- R9: Register 0 is never written: a load whose low-lane target is register 0 clears mask bit 0, and write enable stays low when the mask is empty.
- R10: An issue presented while busy is high is ignored; it makes no memory access.
- R11: While reset is asserted and in the first cycle after it, there is no memory request, busy, done or write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | Instruction valid strobe |
| instr | input | 24 | Instruction word |
| rs_a_sel | output | 4 | Base register select |
| rs_b_sel | output | 4 | Index register select |
| rs_d_sel | output | 4 | Store data select (pair base for doublewords) |
| rs_a_val | input | 24 | Value of base register |
| rs_b_val | input | 24 | Value of index register |
| rs_d_lo_val | input | 24 | Value of register rs_d_sel |
| rs_d_hi_val | input | 24 | Value of register rs_d_sel with bit 0 set |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 24 | Word address |
| mem_wdata | output | 24 | Write data |
| mem_rdata | input | 24 | Read data, one cycle after the request |
| busy | output | 1 | Second cycle of a doubleword access |
| done | output | 1 | Access complete pulse |
| wb_en | output | 1 | Register write-back enable |
| wb_idx | output | 4 | Write-back base register index |
| wb_mask | output | 2 | Lane enables: bit 0 to wb_idx, bit 1 to wb_idx with bit 0 set |
| wb_lo | output | 24 | Write-back low lane |
| wb_hi | output | 24 | Write-back high lane |

## Verification
Every cycle, the assertions check the doubleword sequencing rules: busy lasts one cycle, the second address is one above the first, and done follows. They also check that write-back occurs only with done, that register 0 never receives a lane, that non-memory opcodes raise no request, and that the port is quiet after reset. Only the bench's scenarios can show that the addresses use the correct sign extension and wrap correctly. They also show that the right registers land at the right memory words, and that an issue held during busy leaves memory untouched. These results come from comparing a reference register file and memory after every instruction.

// File: rtl/lsu_pkg.sv
// Package: shared widths and instruction field positions for the load/store unit.
// Assumes a 24-bit instruction with a 6-bit opcode in the top bits.
package lsu_pkg;
    localparam int INSTR_W   = 24;
    localparam int RIDX_W    = 4;
    localparam int OPC_W     = 6;
    localparam int IMM_BASE_W = 10;
    localparam int IMM_IDX_W  = 6;
    // Field positions (least significant bit of each field)
    localparam int OPC_LSB   = INSTR_W - OPC_W;        // 18
    localparam int A_LSB     = OPC_LSB - RIDX_W;       // 14
    localparam int D_LSB     = A_LSB - RIDX_W;         // 10
    localparam int B_LSB     = D_LSB - RIDX_W;         // 6
    // Opcode flag bits, relative to the opcode field
    localparam int OPB_INDEXED = 0;
    localparam int OPB_STORE   = 1;
    localparam int OPB_DOUBLE  = 2;
    localparam logic [2:0] OPC_CLASS_MEM = 3'b100;
endpackage

// File: rtl/lsu_decode.sv
// Module: lsu_decode
// Splits an instruction into its memory-class flags and register selects.
// Assumes the opcode layout in lsu_pkg; pure combinational logic.
module lsu_decode
    import lsu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic               legal,
    output logic               is_store,
    output logic               is_dword,
    output logic               is_indexed,
    output logic [RIDX_W-1:0]  a_idx,
    output logic [RIDX_W-1:0]  b_idx,
    output logic [RIDX_W-1:0]  d_idx,
    output logic [IMM_BASE_W-1:0] imm_base,
    output logic [IMM_IDX_W-1:0]  imm_idx
);
    logic [OPC_W-1:0] opc;

    // Field extraction and flag decode
    always_comb begin
        opc        = instr[OPC_LSB +: OPC_W];
        legal      = (opc[OPC_W-1 -: 3] == OPC_CLASS_MEM);
        is_store   = opc[OPB_STORE];
        is_dword   = opc[OPB_DOUBLE];
        is_indexed = opc[OPB_INDEXED];
        a_idx      = instr[A_LSB +: RIDX_W];
        b_idx      = instr[B_LSB +: RIDX_W];
        d_idx      = is_dword ? {instr[D_LSB+1 +: RIDX_W-1], 1'b0}
                              : instr[D_LSB +: RIDX_W];
        imm_base   = instr[IMM_BASE_W-1:0];
        imm_idx    = instr[IMM_IDX_W-1:0];
    end
endmodule

// File: rtl/lsu_agen.sv
// Module: lsu_agen
// Forms the effective word address from base, optional index and a
// sign-extended immediate whose width depends on the mode.
// Assumes addresses wrap modulo 2^W.
module lsu_agen
    import lsu_pkg::*;
#(
    parameter int W = 24
) (
    input  logic                  is_indexed,
    input  logic [W-1:0]          base_val,
    input  logic [W-1:0]          index_val,
    input  logic [IMM_BASE_W-1:0] imm_base,
    input  logic [IMM_IDX_W-1:0]  imm_idx,
    output logic [W-1:0]          ea
);
    logic [W-1:0] off;

    // Pick and sign-extend the offset, then sum
    always_comb begin
        if (is_indexed)
            off = index_val + {{(W-IMM_IDX_W){imm_idx[IMM_IDX_W-1]}}, imm_idx};
        else
            off = {{(W-IMM_BASE_W){imm_base[IMM_BASE_W-1]}}, imm_base};
        ea = base_val + off;
    end
endmodule

// File: rtl/lsu_seq.sv
// Module: lsu_seq
// Sequences one- and two-cycle memory accesses and the load write-back.
// Assumes a memory that returns read data one cycle after the request and
// a d_idx already forced even for doubleword operations.
module lsu_seq
    import lsu_pkg::*;
#(
    parameter int W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              legal,
    input  logic              is_store,
    input  logic              is_dword,
    input  logic [RIDX_W-1:0] d_idx,
    input  logic [W-1:0]      ea,
    input  logic [W-1:0]      d_lo_val,
    input  logic [W-1:0]      d_hi_val,
    input  logic [W-1:0]      mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [W-1:0]      mem_addr,
    output logic [W-1:0]      mem_wdata,
    output logic              busy,
    output logic              done,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_idx,
    output logic [1:0]        wb_mask,
    output logic [W-1:0]      wb_lo,
    output logic [W-1:0]      wb_hi
);
    typedef enum logic {ST_IDLE, ST_HI} state_t;

    state_t            state;
    logic              accept;
    logic              fin_q;
    logic              st_q;
    logic              dword_q;
    logic [RIDX_W-1:0] d_q;
    logic [W-1:0]      addr_hi_q;
    logic [W-1:0]      hi_q;
    logic [W-1:0]      lo_q;

    assign accept = issue && legal && (state == ST_IDLE);

    // Memory port: issue-cycle request or the latched upper-word request
    always_comb begin
        mem_req   = (state == ST_HI) || accept;
        mem_we    = (state == ST_HI) ? st_q      : is_store;
        mem_addr  = (state == ST_HI) ? addr_hi_q : ea;
        mem_wdata = (state == ST_HI) ? hi_q      : d_lo_val;
        busy      = (state == ST_HI);
    end

    // State, operation capture and low-word capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            fin_q     <= 1'b0;
            st_q      <= 1'b0;
            dword_q   <= 1'b0;
            d_q       <= '0;
            addr_hi_q <= '0;
            hi_q      <= '0;
            lo_q      <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    fin_q <= accept && !is_dword;
                    if (accept) begin
                        st_q    <= is_store;
                        dword_q <= is_dword;
                        d_q     <= d_idx;
                        if (is_dword) begin
                            state     <= ST_HI;
                            addr_hi_q <= ea + W'(1);
                            hi_q      <= d_hi_val;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    lo_q  <= mem_rdata;
                    fin_q <= 1'b1;
                end
            endcase
        end
    end

    // Completion and write-back lanes, with register 0 masked off
    always_comb begin
        done    = fin_q;
        wb_idx  = d_q;
        wb_mask = {dword_q, (d_q != '0)};
        wb_en   = fin_q && !st_q && (wb_mask != 2'b00);
        wb_lo   = dword_q ? lo_q : mem_rdata;
        wb_hi   = mem_rdata;
    end

    assert_busy_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    assert_second_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mem_req && mem_addr == $past(mem_addr) + W'(1)));
    assert_done_after_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> done);
    assert_wb_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);
    assert_no_x0_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && wb_idx == '0) |-> !wb_mask[0]);
    assert_quiet_after_reset_R11: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !wb_en));
endmodule

// File: rtl/lsu_top.sv
// Module: lsu_top
// Load/store unit: decodes memory-class instructions, generates the address
// and drives a word-wide synchronous memory port plus a pair write-back port.
// Assumes an external register file answering the select outputs combinationally.
module lsu_top
    import lsu_pkg::*;
#(
    parameter int W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue,
    input  logic [INSTR_W-1:0] instr,
    output logic [RIDX_W-1:0]  rs_a_sel,
    output logic [RIDX_W-1:0]  rs_b_sel,
    output logic [RIDX_W-1:0]  rs_d_sel,
    input  logic [W-1:0]       rs_a_val,
    input  logic [W-1:0]       rs_b_val,
    input  logic [W-1:0]       rs_d_lo_val,
    input  logic [W-1:0]       rs_d_hi_val,
    output logic               mem_req,
    output logic               mem_we,
    output logic [W-1:0]       mem_addr,
    output logic [W-1:0]       mem_wdata,
    input  logic [W-1:0]       mem_rdata,
    output logic               busy,
    output logic               done,
    output logic               wb_en,
    output logic [RIDX_W-1:0]  wb_idx,
    output logic [1:0]         wb_mask,
    output logic [W-1:0]       wb_lo,
    output logic [W-1:0]       wb_hi
);
    logic                  legal, is_store, is_dword, is_indexed;
    logic [IMM_BASE_W-1:0] imm_base;
    logic [IMM_IDX_W-1:0]  imm_idx;
    logic [W-1:0]          ea;

    lsu_decode u_decode (
        .instr      (instr),
        .legal      (legal),
        .is_store   (is_store),
        .is_dword   (is_dword),
        .is_indexed (is_indexed),
        .a_idx      (rs_a_sel),
        .b_idx      (rs_b_sel),
        .d_idx      (rs_d_sel),
        .imm_base   (imm_base),
        .imm_idx    (imm_idx)
    );

    lsu_agen #(.W(W)) u_agen (
        .is_indexed (is_indexed),
        .base_val   (rs_a_val),
        .index_val  (rs_b_val),
        .imm_base   (imm_base),
        .imm_idx    (imm_idx),
        .ea         (ea)
    );

    lsu_seq #(.W(W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (issue),
        .legal     (legal),
        .is_store  (is_store),
        .is_dword  (is_dword),
        .d_idx     (rs_d_sel),
        .ea        (ea),
        .d_lo_val  (rs_d_lo_val),
        .d_hi_val  (rs_d_hi_val),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .done      (done),
        .wb_en     (wb_en),
        .wb_idx    (wb_idx),
        .wb_mask   (wb_mask),
        .wb_lo     (wb_lo),
        .wb_hi     (wb_hi)
    );

    assert_foreign_opcode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !busy && instr[INSTR_W-1 -: 3] != OPC_CLASS_MEM) |-> !mem_req);
endmodule

// File: tb/lsu_top_tb.sv
module lsu_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 24;
    localparam int MEM_N = 64;
    localparam int N_RANDOM = 300;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue = 1'b0;
    logic [23:0]   instr = '0;
    logic [3:0]    rs_a_sel, rs_b_sel, rs_d_sel;
    logic [W-1:0]  rs_a_val, rs_b_val, rs_d_lo_val, rs_d_hi_val;
    logic          mem_req, mem_we, busy, done, wb_en;
    logic [W-1:0]  mem_addr, mem_wdata, mem_rdata, wb_lo, wb_hi;
    logic [3:0]    wb_idx;
    logic [1:0]    wb_mask;

    logic [W-1:0]  rf [16];
    logic [W-1:0]  mem [MEM_N];
    logic [W-1:0]  m_rf [16];
    logic [W-1:0]  m_mem [MEM_N];

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_top #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
        .rs_a_sel(rs_a_sel), .rs_b_sel(rs_b_sel), .rs_d_sel(rs_d_sel),
        .rs_a_val(rs_a_val), .rs_b_val(rs_b_val),
        .rs_d_lo_val(rs_d_lo_val), .rs_d_hi_val(rs_d_hi_val),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .wb_en(wb_en), .wb_idx(wb_idx),
        .wb_mask(wb_mask), .wb_lo(wb_lo), .wb_hi(wb_hi)
    );

    // Behavioural register file and memory
    assign rs_a_val    = rf[rs_a_sel];
    assign rs_b_val    = rf[rs_b_sel];
    assign rs_d_lo_val = rf[rs_d_sel];
    assign rs_d_hi_val = rf[rs_d_sel | 4'd1];

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
            mem_rdata <= mem[mem_addr[5:0]];
        end
        if (wb_en) begin
            if (wb_mask[0]) rf[wb_idx] <= wb_lo;
            if (wb_mask[1]) rf[wb_idx | 4'd1] <= wb_hi;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] f_ea(input logic [23:0] ins);
        logic [W-1:0] a, b;
        a = m_rf[ins[17:14]];
        b = m_rf[ins[9:6]];
        if (ins[18]) return a + b + {{(W-6){ins[5]}}, ins[5:0]};
        return a + {{(W-10){ins[9]}}, ins[9:0]};
    endfunction

    function automatic logic [23:0] mk(input logic [2:0] flags, input logic [3:0] a, input logic [3:0] d, input logic [9:0] tail);
        return {3'b100, flags, a, d, tail};
    endfunction

    task automatic compare_state(input string tag);
        bit ok = 1'b1;
        for (int i = 0; i < 16; i++) if (rf[i] !== m_rf[i]) ok = 1'b0;
        for (int i = 0; i < MEM_N; i++) if (mem[i] !== m_mem[i]) ok = 1'b0;
        chk(ok, tag, {31'd0, ok}, 32'd1);
    endtask

    // Apply one instruction and check every cycle of it
    task automatic run_op(input logic [23:0] ins, input bit hold_busy);
        bit legal = (ins[23:21] == 3'b100);
        bit st = ins[19];
        bit dw = ins[20];
        logic [3:0] d = dw ? {ins[13:11], 1'b0} : ins[13:10];
        logic [W-1:0] ea = f_ea(ins);
        logic [W-1:0] ea1 = ea + 1;
        logic [W-1:0] exp_lo, exp_hi;
        @(negedge clk);
        instr = ins; issue = 1'b1;
        #1;
        if (!legal) begin
            chk(mem_req == 1'b0, "R1 request on foreign opcode", mem_req, 0);
            @(negedge clk); issue = 1'b0; #1;
            chk(done == 1'b0 && wb_en == 1'b0 && mem_req == 1'b0, "R1 completion on foreign opcode", {done, wb_en}, 0);
            @(negedge clk);
            compare_state("R1 state untouched");
            return;
        end
        chk(mem_req && mem_addr == ea, ins[18] ? "R3 indexed address" : "R2 base address", mem_addr, ea);
        chk(mem_we == st, st ? "R4 store write enable" : "R5 load write enable", mem_we, st);
        chk(busy == 1'b0, "R6 busy in first cycle", busy, 0);
        if (st) chk(mem_wdata == m_rf[d], dw ? "R7 low store data" : "R4 store data", mem_wdata, m_rf[d]);
        exp_lo = m_mem[ea[5:0]];
        exp_hi = m_mem[ea1[5:0]];
        if (!dw) begin
            @(negedge clk); issue = 1'b0; #1;
            chk(done == 1'b1 && busy == 1'b0 && mem_req == 1'b0, st ? "R4 done timing" : "R5 done timing", {done, busy, mem_req}, 3'b100);
            if (st) chk(wb_en == 1'b0, "R4 no write-back on store", wb_en, 0);
            else begin
                chk(wb_en == (d != 0), "R9 write enable for x0 load", wb_en, (d != 0));
                if (d != 0) chk(wb_idx == d && wb_mask == 2'b01 && wb_lo == exp_lo, "R5 load write-back", wb_lo, exp_lo);
            end
            if (st) m_mem[ea[5:0]] = m_rf[d];
            else if (d != 0) m_rf[d] = exp_lo;
        end else begin
            @(negedge clk);
            if (hold_busy) instr = mk(3'b010, 4'd0, 4'd5, 10'h011);
            else issue = 1'b0;
            #1;
            chk(busy && mem_req && mem_addr == ea1 && mem_we == st, "R6 second request", mem_addr, ea1);
            if (st) chk(mem_wdata == m_rf[d | 4'd1], "R7 high store data", mem_wdata, m_rf[d | 4'd1]);
            chk(done == 1'b0, "R6 no done during busy", done, 0);
            @(negedge clk); issue = 1'b0; #1;
            chk(done && !busy, "R6 done after second request", {done, busy}, 2'b10);
            if (st) chk(wb_en == 1'b0, "R7 no write-back on store", wb_en, 0);
            else begin
                chk(wb_en && wb_idx == d && wb_mask == {1'b1, d != 0}, "R9 pair mask", {wb_idx, wb_mask}, {d, 1'b1, d != 0});
                chk(wb_lo == exp_lo && wb_hi == exp_hi, "R8 pair data", {wb_lo[15:0], wb_hi[15:0]}, {exp_lo[15:0], exp_hi[15:0]});
            end
            if (st) begin
                m_mem[ea[5:0]] = m_rf[d];
                m_mem[ea1[5:0]] = m_rf[d | 4'd1];
            end else begin
                if (d != 0) m_rf[d] = exp_lo;
                m_rf[d | 4'd1] = exp_hi;
            end
        end
        @(negedge clk);
        compare_state(hold_busy ? "R10 held issue ignored" : "R7 R8 state match");
    endtask

    initial begin
        int cycles = 0;
        while (cycles < WATCHDOG && !finished) begin
            @(posedge clk);
            cycles++;
        end
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=<%0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 16; i++) rf[i] = (i == 0) ? '0 : W'($urandom);
        for (int i = 0; i < MEM_N; i++) mem[i] = W'($urandom);
        m_rf = rf;
        m_mem = mem;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(!mem_req && !busy && !done && !wb_en, "R11 state in reset", {mem_req, busy, done, wb_en}, 0);
        @(negedge clk); rst_n = 1'b1; #1;
        chk(!mem_req && !busy && !done && !wb_en, "R11 state after reset", {mem_req, busy, done, wb_en}, 0);

        // Directed corner cases
        run_op(mk(3'b000, 4'd3, 4'd4, 10'h3FF), 1'b0);          // R2 negative immediate load
        run_op(mk(3'b001, 4'd2, 4'd6, {4'd7, 6'h20}), 1'b0);    // R3 indexed, immediate -32
        run_op(mk(3'b010, 4'd0, 4'd9, 10'h1FF), 1'b0);          // R4 store from x0 base
        run_op(mk(3'b000, 4'd5, 4'd0, 10'h004), 1'b0);          // R9 word load to x0
        run_op(mk(3'b100, 4'd1, 4'd1, 10'h010), 1'b0);          // R9 pair load to x0/x1
        run_op(mk(3'b110, 4'd4, 4'd11, 10'h020), 1'b0);         // R7 pair store, odd D
        run_op(mk(3'b101, 4'd6, 4'd12, {4'd3, 6'h3F}), 1'b0);   // R8 indexed pair load
        run_op(mk(3'b110, 4'd7, 4'd2, 10'h008), 1'b1);          // R10 issue held during busy
        run_op({6'b110000, 18'h12345}, 1'b0);                   // R1 branch-class opcode
        run_op({6'b101010, 18'h00F0F}, 1'b0);                   // R1 opcode 101xxx

        // Constrained random mix
        for (int n = 0; n < N_RANDOM; n++) begin
            logic [23:0] ins;
            ins = 24'($urandom);
            if (($urandom % 8) != 0) ins[23:21] = 3'b100;
            run_op(ins, ($urandom % 6) == 0);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule